// File: doc/BRIEF.md
# Off-Line Position Sweep Tester

This block runs a one-shot self-test over every channel of an angle output stage. Software starts it by writing 1 to the enable bit of its control register. While the test runs, the block overrides the commanded position of all channels. It steps that position through a fixed ring of test angles. At each angle it waits a programmable number of ticks for the output to settle, then compares the measured angle of each channel against the commanded one. A channel whose error exceeds the tolerance at any angle gets a sticky fail flag. When interrupt enable is set, any raised flag drives the interrupt.

The enable bit reads back as 1 only while the sweep runs. It clears by itself after the last angle, and a one-cycle done pulse marks that completion. Writing 0 stops the sweep at once, and so does losing either the outputs-on or the excitation-present qualifier. A stop keeps the flags gathered so far and gives no done pulse. Angles are unsigned binary fractions of a turn, and the error is taken modulo one turn. The measured angles are sampled levels. They have no handshake and no back-pressure, because the block only reads them on its own compare strobe.

Top module: `sweep_selftest`

## Requirements
- R1: After reset, reg_rdata is 0, ovr_active is 0, test_fail is 0, irq is 0 and sweep_done is 0.
- R2: A write with reg_wdata[3]=1 while idle, with outputs_on and excit_ok both 1, has the following effect in the next cycle: reg_rdata[3]=1, ovr_active=1, ovr_pos=0 and all test_fail bits cleared. If either qualifier is 0, the write is ignored.
- R3: Test point k (k = 0..NUM_POINTS-1, default 72) commands ovr_pos = k*STEP_LSB modulo 2^ANG_W, with a default step of 910 LSB (5 degrees of a 16-bit turn). Each point lasts SETTLE_TICKS tick pulses.
- R4: On the tick that ends a point's settle time, channel c fails if the error |meas - ovr_pos| exceeds TOL_LSB (default 9, about 0.05 degrees). The error is taken as a signed two's-complement difference modulo 2^ANG_W. A failure sets test_fail[c] in the next cycle, and the bit stays set.
- R5: The cycle after the last point's compare, reg_rdata[3] and ovr_active drop to 0 and sweep_done is 1 for exactly one cycle. With a tick every cycle, done appears NUM_POINTS*SETTLE_TICKS cycles after the start write.
- R6: A write with reg_wdata[3]=0 while running stops the sweep in the next cycle. It gives no sweep_done pulse and keeps test_fail.
- R7: If outputs_on or excit_ok is 0 while running, the sweep stops in the next cycle as in R6.
- R8: irq equals irq_enable AND the OR of all test_fail bits.
- R9: A write with reg_wdata[3]=1 while running is ignored: the sweep neither restarts nor jumps position.
- R10: ovr_active always equals reg_rdata[3]. All other reg_rdata bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 16 | Write data; bit 3 is the enable |
| reg_rdata | output | 16 | Control readback; bit 3 is running |
| meas_pos | input | NUM_CH*ANG_W | Measured angles, channel 0 in the low bits |
| outputs_on | input | 1 | Output stage enabled qualifier |
| excit_ok | input | 1 | Excitation present qualifier |
| tick | input | 1 | Settle time base pulse |
| irq_enable | input | 1 | Interrupt enable |
| ovr_pos | output | ANG_W | Override commanded position |
| ovr_active | output | 1 | Override in force |
| test_fail | output | NUM_CH | Sticky per-channel fail flags |
| irq | output | 1 | Interrupt request (level) |
| sweep_done | output | 1 | One-cycle completion pulse |

## Verification
All control results (start, stop, qualifier loss, completion) take effect one clock edge after the cause. The bench drives on the falling edge and samples on the following falling edge, so each check sees the value registered by the one edge in between. Fail flags follow a compare by one edge. Because the bench derives the measured angle combinationally from ovr_pos plus a per-channel offset, the expected flag depends only on that offset. The total sweep length is checked by counting edges from the start write to the done pulse.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  // Bit of the control register that starts, reports and stops the sweep.
  localparam int unsigned ENABLE_BIT = 3;
  localparam int unsigned REG_W      = 16;
endpackage

// File: rtl/sweep_ctrl.sv
module sweep_ctrl #(
  parameter int unsigned NUM_POINTS   = 72,
  parameter int unsigned SETTLE_TICKS = 410,
  parameter int unsigned ANG_W        = 16,
  parameter int unsigned STEP_LSB     = 910
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             quals_ok,
  input  logic             tick,
  output logic             running,
  output logic             clear_flags,
  output logic             sample,
  output logic             done,
  output logic [ANG_W-1:0] pos
);
  localparam int unsigned IDX_W = $clog2(NUM_POINTS + 1);
  localparam int unsigned CNT_W = $clog2(SETTLE_TICKS + 1);
  localparam logic [ANG_W-1:0] STEP_V   = ANG_W'(STEP_LSB);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_POINTS - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SETTLE_TICKS - 1);

  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt;
  logic             halt, at_end;

  always_comb begin
    halt        = running && (stop_req || !quals_ok);
    at_end      = running && tick && (cnt == LAST_CNT);
    sample      = at_end && !halt;
    clear_flags = !running && start_req && quals_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      done    <= 1'b0;
      idx     <= '0;
      cnt     <= '0;
      pos     <= '0;
    end else begin
      done <= 1'b0;
      if (!running) begin
        if (clear_flags) begin
          running <= 1'b1;
          idx     <= '0;
          cnt     <= '0;
          pos     <= '0;
        end
      end else if (halt) begin
        running <= 1'b0;
      end else if (at_end) begin
        cnt <= '0;
        if (idx == LAST_IDX) begin
          running <= 1'b0;
          done    <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
          pos <= pos + STEP_V;
        end
      end else if (tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: the override position only moves forward by one step
  p_pos_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && (pos != $past(pos))) |-> (pos == $past(pos) + STEP_V));
  // R2: a qualified start from idle begins at angle zero
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && start_req && quals_ok) |=> (running && pos == '0));
  // R6: a stop write ends the sweep without a done pulse
  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && stop_req) |=> (!running && !done));
  // R7: losing a qualifier ends the sweep
  p_qual_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !quals_ok) |=> !running);
  // R5: completion pulse only once the sweep has ended, and only one cycle long
  p_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!running && $past(running)));
  p_done_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/chan_cmp.sv
module chan_cmp #(
  parameter int unsigned ANG_W   = 16,
  parameter int unsigned TOL_LSB = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample,
  input  logic [ANG_W-1:0] cmd_pos,
  input  logic [ANG_W-1:0] meas,
  output logic             flag
);
  logic [ANG_W-1:0] diff, mag;
  logic             bad;

  always_comb begin
    diff = meas - cmd_pos;
    mag  = diff[ANG_W-1] ? (~diff + 1'b1) : diff;
    bad  = (mag > ANG_W'(TOL_LSB));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              flag <= 1'b0;
    else if (clear)          flag <= 1'b0;
    else if (sample && bad)  flag <= 1'b1;
  end

  // R4: a raised flag holds until the next sweep start
  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clear) |=> flag);
  // R4: a flag only rises on a compare strobe
  p_flag_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !sample) |=> !flag);
endmodule

// File: rtl/sweep_selftest.sv
module sweep_selftest
  import sweep_pkg::*;
#(
  parameter int unsigned NUM_CH       = 2,
  parameter int unsigned ANG_W        = 16,
  parameter int unsigned NUM_POINTS   = 72,
  parameter int unsigned SETTLE_TICKS = 410,
  parameter int unsigned STEP_LSB     = 910,
  parameter int unsigned TOL_LSB      = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [REG_W-1:0]        reg_wdata,
  output logic [REG_W-1:0]        reg_rdata,
  input  logic [NUM_CH*ANG_W-1:0] meas_pos,
  input  logic                    outputs_on,
  input  logic                    excit_ok,
  input  logic                    tick,
  input  logic                    irq_enable,
  output logic [ANG_W-1:0]        ovr_pos,
  output logic                    ovr_active,
  output logic [NUM_CH-1:0]       test_fail,
  output logic                    irq,
  output logic                    sweep_done
);
  logic running, clear_flags, sample, start_req, stop_req, quals_ok;
  logic wdata_unused;

  assign start_req    = reg_we && reg_wdata[ENABLE_BIT];
  assign stop_req     = reg_we && !reg_wdata[ENABLE_BIT];
  assign quals_ok     = outputs_on && excit_ok;
  assign wdata_unused = ^{reg_wdata[REG_W-1:ENABLE_BIT+1], reg_wdata[ENABLE_BIT-1:0]};

  sweep_ctrl #(
    .NUM_POINTS(NUM_POINTS), .SETTLE_TICKS(SETTLE_TICKS),
    .ANG_W(ANG_W), .STEP_LSB(STEP_LSB)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .quals_ok(quals_ok), .tick(tick), .running(running),
    .clear_flags(clear_flags), .sample(sample), .done(sweep_done), .pos(ovr_pos)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_cmp #(.ANG_W(ANG_W), .TOL_LSB(TOL_LSB)) u_cmp (
      .clk(clk), .rst_n(rst_n), .clear(clear_flags), .sample(sample),
      .cmd_pos(ovr_pos), .meas(meas_pos[c*ANG_W +: ANG_W]), .flag(test_fail[c])
    );
  end

  always_comb begin
    reg_rdata             = '0;
    reg_rdata[ENABLE_BIT] = running;
  end

  assign ovr_active = running;
  assign irq        = irq_enable && (|test_fail);

  // R9: a further enable write while running leaves the position alone
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start_req && quals_ok && !sample) |=> $stable(ovr_pos));
  // R8: interrupt only with enable and a raised flag
  p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_enable && test_fail != '0));
endmodule

// File: tb/tb_sweep_selftest.sv
module tb_sweep_selftest;
  localparam int NCH = 2, W = 16, NPT = 72, ST = 3, STEP = 910, TOL = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [NCH*W-1:0] meas_pos;
  logic outputs_on = 1'b1, excit_ok = 1'b1, tick = 1'b1, irq_enable = 1'b0;
  logic [W-1:0] ovr_pos, off0 = '0, off1 = '0;
  logic ovr_active, irq, sweep_done;
  logic [NCH-1:0] test_fail;

  int n_chk = 0, n_fail = 0;
  int done_cnt = 0, step_err = 0, mirror_err = 0, done_len_err = 0;
  logic prev_act = 1'b0, prev_done = 1'b0;
  logic [W-1:0] prev_pos = '0;

  always #5 clk = ~clk;

  assign meas_pos = {ovr_pos + off1, ovr_pos + off0};

  sweep_selftest #(.NUM_CH(NCH), .ANG_W(W), .NUM_POINTS(NPT), .SETTLE_TICKS(ST),
                   .STEP_LSB(STEP), .TOL_LSB(TOL)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .meas_pos(meas_pos), .outputs_on(outputs_on),
    .excit_ok(excit_ok), .tick(tick), .irq_enable(irq_enable), .ovr_pos(ovr_pos),
    .ovr_active(ovr_active), .test_fail(test_fail), .irq(irq), .sweep_done(sweep_done));

  function automatic bit exceeds(input int off);
    return (off > TOL) || (off < -TOL);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor at falling edges: R3 step order, R10 mirror, R5 done width
  always @(negedge clk) if (rst_n) begin
    if (ovr_active !== reg_rdata[3] || (reg_rdata & 16'hFFF7) !== 16'h0) mirror_err++;
    if (ovr_active && !prev_act && ovr_pos !== '0) step_err++;
    if (ovr_active && prev_act && ovr_pos !== prev_pos && ovr_pos !== W'(prev_pos + STEP)) step_err++;
    if (sweep_done) done_cnt++;
    if (sweep_done && prev_done) done_len_err++;
    prev_act = ovr_active; prev_pos = ovr_pos; prev_done = sweep_done;
  end

  task automatic reg_write(input bit en);
    @(negedge clk);
    reg_we = 1'b1;
    reg_wdata = (16'($urandom) & 16'hFFF7) | (en ? 16'h0008 : 16'h0000);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    while (!sweep_done && k < 5000) begin @(negedge clk); k++; end
  endtask

  task automatic settle_irq_check(input string req);
    check(irq === (irq_enable && (|test_fail)), req, irq, irq_enable && (|test_fail));
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int k, d0, o0, o1;
    logic [W-1:0] hold;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reg_rdata == 16'h0, "R1 rdata", reg_rdata, 0);
    check(!ovr_active && test_fail == '0, "R1 active/fail", {ovr_active, test_fail}, 0);
    check(!irq && !sweep_done, "R1 irq/done", {irq, sweep_done}, 0);

    // R2 start ignored without excitation
    excit_ok = 1'b0;
    reg_write(1'b1);
    @(negedge clk);
    check(reg_rdata[3] == 1'b0, "R2 start without qualifier ignored", reg_rdata[3], 0);
    excit_ok = 1'b1;

    // Directed sweep: ch0 at tolerance edge (9), ch1 just past (-10)
    off0 = W'(9); off1 = W'(-10); irq_enable = 1'b1;
    d0 = done_cnt;
    reg_write(1'b1);
    check(reg_rdata[3] && ovr_active && ovr_pos == 0, "R2 start", {reg_rdata[3], ovr_pos}, 2);
    check(test_fail == '0, "R2 flags clear at start", test_fail, 0);
    wait_done(k);
    check(k == NPT * ST, "R5 sweep length", k, NPT * ST);
    check(!reg_rdata[3] && !ovr_active, "R5 self-clear", reg_rdata[3], 0);
    check(test_fail == 2'b10, "R4 tolerance edge 9 pass / -10 fail", test_fail, 2);
    settle_irq_check("R8 irq enabled");
    irq_enable = 1'b0;
    @(negedge clk);
    settle_irq_check("R8 irq masked");
    check(done_cnt == d0 + 1, "R5 one done pulse", done_cnt - d0, 1);

    // Wrap near zero: -9 passes across the 0/65535 boundary, +10 fails
    off0 = W'(-9); off1 = W'(10);
    reg_write(1'b1);
    wait_done(k);
    check(test_fail == 2'b10, "R4 wrap-around error", test_fail, 2);

    // Random offsets and random tick pacing
    for (int s = 0; s < 6; s++) begin
      o0 = int'($urandom_range(24)) - 12;
      o1 = int'($urandom_range(24)) - 12;
      off0 = W'(o0); off1 = W'(o1);
      irq_enable = $urandom_range(1);
      reg_write(1'b1);
      while (!sweep_done && reg_rdata[3]) begin
        tick = $urandom_range(1);
        @(negedge clk);
      end
      tick = 1'b1;
      check(sweep_done, "R5 random sweep completes", sweep_done, 1);
      check(test_fail == {exceeds(o1), exceeds(o0)}, "R4 random offsets", test_fail,
            {exceeds(o1), exceeds(o0)});
      settle_irq_check("R8 random irq");
      @(negedge clk);
    end

    // R9: re-enable while running has no effect
    off0 = W'(15); off1 = '0;
    reg_write(1'b1);
    while (ovr_pos < W'(3 * STEP)) @(negedge clk);
    @(negedge clk);
    hold = ovr_pos;
    reg_write(1'b1);
    check(reg_rdata[3] && ovr_pos >= hold, "R9 re-enable ignored", ovr_pos, hold);

    // R6: abort mid-sweep keeps flags, gives no done
    while (ovr_pos < W'(10 * STEP)) @(negedge clk);
    d0 = done_cnt;
    reg_write(1'b0);
    check(!reg_rdata[3] && !ovr_active, "R6 abort stops", reg_rdata[3], 0);
    check(test_fail == 2'b01, "R6 flags kept after abort", test_fail, 1);
    repeat (5) @(negedge clk);
    check(done_cnt == d0, "R6 no done on abort", done_cnt - d0, 0);

    // R2: new sweep clears old flags; R7: qualifier loss stops
    off0 = '0;
    reg_write(1'b1);
    check(test_fail == 2'b00, "R2 new sweep clears flags", test_fail, 0);
    repeat (20) @(negedge clk);
    d0 = done_cnt;
    outputs_on = 1'b0;
    @(negedge clk);
    check(!reg_rdata[3] && !ovr_active, "R7 qualifier loss stops", reg_rdata[3], 0);
    outputs_on = 1'b1;
    repeat (5) @(negedge clk);
    check(done_cnt == d0 && !reg_rdata[3], "R7 no done, stays stopped", done_cnt - d0, 0);

    check(step_err == 0, "R3 angle sequence", step_err, 0);
    check(mirror_err == 0, "R10 active mirrors bit 3", mirror_err, 0);
    check(done_len_err == 0, "R5 done width", done_len_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule